// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is the output stage that follows a programmable AND-OR array. Every cell receives its own OR-ed sum and its own enable product term. All cells share one synchronous set term and one asynchronous reset term. Two static configuration bits shape each cell. One bit picks registered operation, where a rising-edge D flip-flop holds the sum, or combinational operation, where the sum goes straight through. The other bit picks whether the value is inverted before it reaches the pin.

Each cell produces three outputs: a pin value, a pin drive enable and a feedback bit that goes back into the array. In registered mode the feedback carries the register state. In combinational mode it carries the pin: the driven value while the cell drives the pin, or the externally applied level while the pin is released and serves as an input. A test preload path can load any value into the registers. A power-up clear leaves every register at 0, so the pin of a registered cell comes up at the level that its polarity gives.

The bank width is a parameter. Configuration is static in normal use and is changed only around a power-up clear.

Top module: `mc_bank`

## Requirements
- R1: While `rst` is high at a rising edge, every register becomes 0. After that edge a registered cell drives `pin_out` low when its `cfg_invert` bit is 0 and high when the bit is 1.
- R2: In registered mode (`cfg_registered` bit = 1), with no set, reset or preload active, the register takes `sum_in` at each rising edge. After the edge, `pin_out` shows that value through the cell's polarity, and `fb_out` shows the uninverted register state.
- R3: In combinational mode (`cfg_registered` bit = 0), `pin_out` equals `sum_in` XOR `cfg_invert` in the same cycle. The set, reset and preload terms have no effect on it.
- R4: `cfg_invert` = 1 inverts the pin value in both modes. `cfg_invert` = 0 passes the value through unchanged.
- R5: When `set_term` is 1 at a rising edge, every register loads 1 at that edge and not before it. A registered cell's pin then reads the inverse of its `cfg_invert` bit.
- R6: While `areset_term` is 1, every register is 0 at once, without a clock edge. A registered cell's pin then equals its `cfg_invert` bit.
- R7: When `preload_en` is 1 at a rising edge, each register loads its bit of `preload_val`.
- R8: Load priority, from highest to lowest: `areset_term`, `rst`, `set_term`, `preload_en`, then the clocked `sum_in`.
- R9: `pin_oe` of each cell equals its `oe_term` bit. `pin_out` carries the cell's value whatever the enable.
- R10: In combinational mode, `fb_out` equals `pin_out` while `oe_term` is 1 and equals `pin_in` while `oe_term` is 0. In registered mode, `fb_out` equals the register state whatever the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers update on its rising edge |
| rst | input | 1 | Synchronous power-up clear, active high |
| sum_in | input | W | OR-ed sum of each cell |
| oe_term | input | W | Enable product term of each cell |
| set_term | input | 1 | Shared synchronous set term |
| areset_term | input | 1 | Shared asynchronous reset term |
| preload_en | input | 1 | Test preload strobe |
| preload_val | input | W | Register values to preload |
| cfg_registered | input | W | 1 = registered, 0 = combinational, per cell |
| cfg_invert | input | W | 1 = inverted pin value, per cell |
| pin_in | input | W | Level applied to the pin from outside |
| pin_out | output | W | Value each cell drives onto its pin |
| pin_oe | output | W | Drive enable of each pin |
| fb_out | output | W | Feedback bit of each cell into the array |

## Verification
Several load sources can be active on the same rising edge, and the bench provokes these collisions on purpose. One cycle raises set and preload together. Another pairs preload with a conflicting sum. A third holds the asynchronous reset high while set is also high, and a fourth asserts the power-up clear with set. The scoreboard model applies the stated priority and predicts the register state after each edge. The asynchronous reset is also judged inside the clock low phase, before any edge, to show that it acts without a clock.

// File: rtl/macro_pkg.sv
package macro_pkg;

    typedef enum logic {
        MODE_COMB = 1'b0,
        MODE_REG  = 1'b1
    } cell_mode_e;

    typedef struct packed {
        cell_mode_e mode;
        logic       invert;
    } cell_cfg_t;

    typedef enum logic [1:0] {
        LD_DATA  = 2'd0,
        LD_PRE   = 2'd1,
        LD_SET   = 2'd2,
        LD_CLEAR = 2'd3
    } load_sel_e;

    typedef struct packed {
        logic srst;
        logic set;
        logic pre;
    } load_req_t;

    // Clocked load source by priority (the asynchronous clear sits outside)
    function automatic load_sel_e pick_load(load_req_t req);
        if (req.srst)      return LD_CLEAR;
        else if (req.set)  return LD_SET;
        else if (req.pre)  return LD_PRE;
        else               return LD_DATA;
    endfunction

    function automatic logic apply_pol(logic v, logic inv);
        return v ^ inv;
    endfunction

endpackage

// File: rtl/mc_load_ctl.sv
module mc_load_ctl
    import macro_pkg::*;
(
    input  logic      rst,
    input  logic      set_term,
    input  logic      preload_en,
    output load_sel_e sel
);
    load_req_t req;

    always_comb begin
        req.srst = rst;
        req.set  = set_term;
        req.pre  = preload_en;
        sel      = pick_load(req);
    end
endmodule

// File: rtl/mc_store.sv
module mc_store
    import macro_pkg::*;
(
    input  logic      clk,
    input  logic      areset_term,
    input  load_sel_e sel,
    input  logic      d,
    input  logic      pre_val,
    output logic      q
);
    logic nxt;

    always_comb begin
        unique case (sel)
            LD_CLEAR: nxt = 1'b0;
            LD_SET:   nxt = 1'b1;
            LD_PRE:   nxt = pre_val;
            default:  nxt = d;
        endcase
    end

    always_ff @(posedge clk or posedge areset_term) begin
        if (areset_term) q <= 1'b0;
        else             q <= nxt;
    end
endmodule

// File: rtl/mc_route.sv
module mc_route
    import macro_pkg::*;
(
    input  cell_cfg_t cfg,
    input  logic      d,
    input  logic      q,
    input  logic      oe,
    input  logic      pin_ext,
    output logic      pin_val,
    output logic      pin_en,
    output logic      fb
);
    logic raw;

    always_comb begin
        raw     = (cfg.mode == MODE_REG) ? q : d;
        pin_val = apply_pol(raw, cfg.invert);
        pin_en  = oe;
        if (cfg.mode == MODE_REG) fb = q;
        else if (oe)              fb = pin_val;
        else                      fb = pin_ext;
    end
endmodule

// File: rtl/mc_bank.sv
module mc_bank
    import macro_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sum_in,
    input  logic [W-1:0] oe_term,
    input  logic         set_term,
    input  logic         areset_term,
    input  logic         preload_en,
    input  logic [W-1:0] preload_val,
    input  logic [W-1:0] cfg_registered,
    input  logic [W-1:0] cfg_invert,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] fb_out
);
    load_sel_e sel;

    mc_load_ctl u_ctl (
        .rst        (rst),
        .set_term   (set_term),
        .preload_en (preload_en),
        .sel        (sel)
    );

    for (genvar i = 0; i < W; i++) begin : g_cell
        cell_cfg_t cfg;
        logic      q;

        always_comb begin
            cfg.mode   = cfg_registered[i] ? MODE_REG : MODE_COMB;
            cfg.invert = cfg_invert[i];
        end

        mc_store u_store (
            .clk         (clk),
            .areset_term (areset_term),
            .sel         (sel),
            .d           (sum_in[i]),
            .pre_val     (preload_val[i]),
            .q           (q)
        );

        mc_route u_route (
            .cfg     (cfg),
            .d       (sum_in[i]),
            .q       (q),
            .oe      (oe_term[i]),
            .pin_ext (pin_in[i]),
            .pin_val (pin_out[i]),
            .pin_en  (pin_oe[i]),
            .fb      (fb_out[i])
        );
    end
endmodule

// File: rtl/mc_bank_chk.sv
module mc_bank_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] sum_in,
    input logic [W-1:0] oe_term,
    input logic         set_term,
    input logic         areset_term,
    input logic         preload_en,
    input logic [W-1:0] preload_val,
    input logic [W-1:0] cfg_registered,
    input logic [W-1:0] cfg_invert,
    input logic [W-1:0] pin_in,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe,
    input logic [W-1:0] fb_out
);
    for (genvar i = 0; i < W; i++) begin : g_chk
        assert_comb_path_R3: assert property (@(posedge clk) disable iff (rst)
            !cfg_registered[i] |-> pin_out[i] == (sum_in[i] ^ cfg_invert[i]));

        assert_reg_capture_R2: assert property (@(posedge clk) disable iff (rst)
            (cfg_registered[i] && !areset_term && !set_term && !preload_en)
            |=> (areset_term || fb_out[i] == $past(sum_in[i])));

        assert_set_load_R5: assert property (@(posedge clk) disable iff (rst)
            (cfg_registered[i] && set_term && !areset_term)
            |=> (areset_term || fb_out[i]));

        assert_preload_R7: assert property (@(posedge clk) disable iff (rst)
            (cfg_registered[i] && preload_en && !set_term && !areset_term)
            |=> (areset_term || fb_out[i] == $past(preload_val[i])));

        assert_async_clear_R6: assert property (@(posedge clk) disable iff (rst)
            (cfg_registered[i] && areset_term) |-> !fb_out[i]);

        assert_reg_polarity_R4: assert property (@(posedge clk) disable iff (rst)
            cfg_registered[i] |-> pin_out[i] == (fb_out[i] ^ cfg_invert[i]));

        assert_fb_release_R10: assert property (@(posedge clk) disable iff (rst)
            (!cfg_registered[i] && !oe_term[i]) |-> fb_out[i] == pin_in[i]);

        assert_enable_R9: assert property (@(posedge clk) disable iff (rst)
            pin_oe[i] == oe_term[i]);
    end
endmodule

bind mc_bank mc_bank_chk #(.W(W)) u_chk (.*);

// File: tb/tb_mc_bank.sv
`timescale 1ns/1ps
module tb_mc_bank;
    localparam int W = 4;

    typedef struct {
        logic [W-1:0] pin;
        logic [W-1:0] oe;
        logic [W-1:0] fb;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] sum_in = '0, oe_term = '0, preload_val = '0, pin_in = '0;
    logic [W-1:0] cfg_registered = 4'b0011, cfg_invert = 4'b1010;
    logic         set_term = 1'b0, areset_term = 1'b0, preload_en = 1'b0;
    logic [W-1:0] pin_out, pin_oe, fb_out;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t sb[$];
    logic [W-1:0] q_m = '0;

    always #2 clk = ~clk;

    mc_bank #(.W(W)) dut (.*);

    function automatic exp_t predict(logic [W-1:0] q, string tag);
        exp_t e;
        for (int i = 0; i < W; i++) begin
            logic v;
            v = (cfg_registered[i] ? q[i] : sum_in[i]) ^ cfg_invert[i];
            e.pin[i] = v;
            e.oe[i]  = oe_term[i];
            e.fb[i]  = cfg_registered[i] ? q[i] : (oe_term[i] ? v : pin_in[i]);
        end
        e.tag = tag;
        return e;
    endfunction

    task automatic compare(exp_t e);
        n_checks++;
        if (pin_out !== e.pin || pin_oe !== e.oe || fb_out !== e.fb) begin
            n_errors++;
            $display("FAIL %s: pin=%b oe=%b fb=%b expected pin=%b oe=%b fb=%b",
                     e.tag, pin_out, pin_oe, fb_out, e.pin, e.oe, e.fb);
        end
    endtask

    task automatic step(input logic r, input logic [W-1:0] s, input logic [W-1:0] oe,
                        input logic st, input logic ar, input logic pe,
                        input logic [W-1:0] pv, input logic [W-1:0] pi, input string tag);
        @(negedge clk);
        rst = r; sum_in = s; oe_term = oe; set_term = st;
        areset_term = ar; preload_en = pe; preload_val = pv; pin_in = pi;
        if (ar) begin
            q_m = '0;
            #1;
            compare(predict(q_m, {tag, " (no clock edge)"}));
        end
        if (ar || r)    q_m = '0;
        else if (st)    q_m = '1;
        else if (pe)    q_m = pv;
        else            q_m = s;
        sb.push_back(predict(q_m, tag));
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) compare(sb.pop_front());
        end
    end

    initial begin : watchdog
        #(200000 * 4);
        n_errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : driver
        // cells: 0 reg/true, 1 reg/inverted, 2 comb/true, 3 comb/inverted
        step(1, 4'b0000, 4'b1111, 0, 0, 0, 4'b0000, 4'b0000, "R1 power-up clear");
        step(1, 4'b1111, 4'b1111, 1, 0, 0, 4'b0000, 4'b0000, "R1 R8 clear beats set");
        step(0, 4'b0101, 4'b1111, 0, 0, 0, 4'b0000, 4'b0000, "R2 R3 R4 data 0101");
        step(0, 4'b1010, 4'b0110, 0, 0, 0, 4'b0000, 4'b1001, "R9 R10 partial enable");
        step(0, 4'b1111, 4'b1111, 0, 0, 0, 4'b0000, 4'b0000, "R2 data 1111");
        step(0, 4'b0000, 4'b0000, 0, 0, 0, 4'b0000, 4'b1111, "R10 pins released");
        step(0, 4'b0000, 4'b1111, 1, 0, 0, 4'b0000, 4'b0000, "R5 R3 set with sum 0");
        step(0, 4'b1100, 4'b1111, 0, 0, 1, 4'b0010, 4'b0000, "R7 preload 0010");
        step(0, 4'b1111, 4'b1111, 1, 0, 1, 4'b0000, 4'b0000, "R8 set beats preload");
        step(0, 4'b0011, 4'b1111, 0, 0, 1, 4'b0001, 4'b0000, "R8 preload beats data");
        step(0, 4'b1111, 4'b1111, 1, 1, 0, 4'b0000, 4'b0000, "R6 R8 async reset beats set");
        step(0, 4'b1111, 4'b0101, 0, 0, 0, 4'b0000, 4'b1010, "R2 R10 after async reset");
        step(0, 4'b0110, 4'b1111, 0, 1, 1, 4'b1111, 4'b0000, "R6 R8 async reset beats preload");
        step(1, 4'b1111, 4'b1111, 0, 0, 1, 4'b1111, 4'b0000, "R8 clear beats preload");
        // reconfigure around a power-up clear: 0 comb/true, 1 comb/inverted,
        // 2 reg/inverted, 3 reg/true
        @(negedge clk);
        cfg_registered = 4'b1100; cfg_invert = 4'b0110;
        step(1, 4'b0000, 4'b1111, 0, 0, 0, 4'b0000, 4'b0000, "R1 R4 clear, new config");
        step(0, 4'b1001, 4'b1111, 0, 0, 0, 4'b0000, 4'b0000, "R2 R4 data 1001");
        step(0, 4'b0110, 4'b1100, 0, 0, 0, 4'b0000, 4'b0010, "R10 R9 comb released");
        step(0, 4'b0011, 4'b1111, 1, 0, 0, 4'b0000, 4'b0000, "R5 R3 set new config");
        step(0, 4'b0000, 4'b1111, 0, 0, 1, 4'b1000, 4'b0000, "R7 preload 1000");
        step(0, 4'b1010, 4'b1111, 0, 1, 0, 4'b0000, 4'b0000, "R6 async reset new config");
        step(0, 4'b0101, 4'b0011, 0, 0, 0, 4'b0000, 4'b0000, "R2 R3 final data");
        @(negedge clk);
        areset_term = 1'b0;
        @(negedge clk);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule